// File: doc/BRIEF.md
# Dual-Issue Pipe Reservation and Operand Scoreboard

This block sits in the issue stage of a small in-order core that has two issue slots and four execution pipes: a complex integer pipe, a simple integer pipe, a memory pipe and a floating-point pipe. In every cycle the decoder offers up to two instructions. Slot 0 holds the older one and slot 1 the younger one. Each carries an operation class, a destination register and up to two source registers. The block decides in the same cycle which of them issue and binds each granted instruction to a pipe.

Two kinds of state sit behind that decision. The first is a busy countdown per pipe, so that long divides lock their pipe for many cycles. The second is a countdown per register giving the cycles left until its result exists, so that consumers wait for their operands. A plain integer operation is the only class that may use either integer pipe. A floating-point compare takes the floating-point pipe and the complex integer pipe together.

Top module: `issue_sched`

## Requirements
- R1: A slot is granted only when it is valid. Slot 1 is granted only in a cycle where slot 0 is granted, so an older instruction that stalls also holds the younger one. While reset is high, no grant is given.
- R2: Class codes: 0 integer, 1 multiply, 2 short multiply, 3 integer divide, 4 branch, 5 compare, 6 move-to-condition, 7 move-to-link/count, 8 move-from-link/count, 9 load, 10 FP load, 11 store, 12 FP store, 13 FP arithmetic, 14 single divide, 15 double divide, 16 FP compare. Pipe codes: 0 complex integer, 1 simple integer, 2 memory, 3 floating point. An integer op (class 0) takes pipe 0 when it is free, otherwise pipe 1.
- R3: Classes 1 to 8 issue only on pipe 0.
- R4: Classes 9 to 12 issue only on pipe 2. Classes 13 to 15 issue only on pipe 3.
- R5: A granted instruction with a destination makes any instruction that reads that register wait L cycles. It may issue L cycles after the producer. L is 1 for classes 0, 4 and 11; 2 for 2, 5 and 8; 3 for 1, 6, 9, 12 and 16; 4 for 7 and 10; 5 for 13; 34 for 3; 19 for 14; and 33 for 15.
- R6: A granted instruction keeps its pipe busy for 33 cycles (class 3), 15 cycles (class 14), 29 cycles (class 15) or 1 cycle (all other classes). The same pipe can be granted again only after that many cycles.
- R7: An FP compare (class 16) needs pipes 3 and 0 free together. It reports pipe 3, and it takes pipe 0 away from the other slot in that cycle.
- R8: When both slots need the same pipe, slot 0 gets it. The two granted slots never report the same pipe.
- R9: Slot 1 is held when one of its enabled sources equals the enabled destination of slot 0 in the same cycle.
- R10: Reset clears every pipe countdown and every register countdown, so any instruction can issue in the first cycle after reset.
- R11: A source whose enable bit is low is not checked against the scoreboard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_valid | input | 2 | Instruction present, bit s for slot s |
| slot_class | input | 10 | Operation class, 5 bits per slot, slot 0 in the low bits |
| slot_dst | input | 10 | Destination register index, 5 bits per slot |
| slot_dst_en | input | 2 | Destination written |
| slot_srca | input | 10 | First source register index, 5 bits per slot |
| slot_srca_en | input | 2 | First source used |
| slot_srcb | input | 10 | Second source register index, 5 bits per slot |
| slot_srcb_en | input | 2 | Second source used |
| grant | output | 2 | Slot issues this cycle |
| slot_pipe | output | 4 | Pipe bound to each slot, 2 bits per slot |

## Verification
An internal countdown that is wrong shows up directly in the grants. If a pipe or register counter is off by one, the first probe that follows the producer is granted one cycle early or one cycle late. The bench therefore measures the grant delay for every class and compares it with the expected latency and occupancy. A wrong steering or priority decision shows up in the same cycle as a wrong slot_pipe code or grant pattern, so the paired-slot cases are checked combinationally before the clock edge.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int CLS_W  = 5;
    localparam int PIPE_W = 2;
    localparam int NPIPE  = 4;
    localparam int CNT_W  = 6;

    localparam logic [CLS_W-1:0] OP_INT    = 5'd0;
    localparam logic [CLS_W-1:0] OP_MUL    = 5'd1;
    localparam logic [CLS_W-1:0] OP_MULS   = 5'd2;
    localparam logic [CLS_W-1:0] OP_IDIV   = 5'd3;
    localparam logic [CLS_W-1:0] OP_BR     = 5'd4;
    localparam logic [CLS_W-1:0] OP_CMP    = 5'd5;
    localparam logic [CLS_W-1:0] OP_TOCR   = 5'd6;
    localparam logic [CLS_W-1:0] OP_TOLNK  = 5'd7;
    localparam logic [CLS_W-1:0] OP_FRLNK  = 5'd8;
    localparam logic [CLS_W-1:0] OP_LD     = 5'd9;
    localparam logic [CLS_W-1:0] OP_FLD    = 5'd10;
    localparam logic [CLS_W-1:0] OP_ST     = 5'd11;
    localparam logic [CLS_W-1:0] OP_FST    = 5'd12;
    localparam logic [CLS_W-1:0] OP_FARITH = 5'd13;
    localparam logic [CLS_W-1:0] OP_FDIVS  = 5'd14;
    localparam logic [CLS_W-1:0] OP_FDIVD  = 5'd15;
    localparam logic [CLS_W-1:0] OP_FCMP   = 5'd16;

    typedef enum logic [PIPE_W-1:0] {
        PIPE_CX  = 2'd0,
        PIPE_SX  = 2'd1,
        PIPE_MEM = 2'd2,
        PIPE_FP  = 2'd3
    } pipe_e;

    typedef struct packed {
        logic             ok;
        logic [PIPE_W-1:0] pipe;
        logic [NPIPE-1:0]  mask;
    } pick_t;

    // Cycles until a consumer of the result may issue.
    function automatic logic [CNT_W-1:0] op_latency(logic [CLS_W-1:0] c);
        case (c)
            OP_MULS, OP_CMP, OP_FRLNK:        return 6'd2;
            OP_MUL, OP_TOCR, OP_LD, OP_FST,
            OP_FCMP:                          return 6'd3;
            OP_TOLNK, OP_FLD:                 return 6'd4;
            OP_FARITH:                        return 6'd5;
            OP_FDIVS:                         return 6'd19;
            OP_FDIVD:                         return 6'd33;
            OP_IDIV:                          return 6'd34;
            default:                          return 6'd1;
        endcase
    endfunction

    // Cycles for which the bound pipe stays reserved.
    function automatic logic [CNT_W-1:0] op_occupancy(logic [CLS_W-1:0] c);
        case (c)
            OP_IDIV:  return 6'd33;
            OP_FDIVS: return 6'd15;
            OP_FDIVD: return 6'd29;
            default:  return 6'd1;
        endcase
    endfunction

    function automatic pipe_e op_home(logic [CLS_W-1:0] c);
        if (c >= OP_LD && c <= OP_FST)        return PIPE_MEM;
        if (c >= OP_FARITH && c <= OP_FCMP)   return PIPE_FP;
        return PIPE_CX;
    endfunction

    // Choose a pipe for class c out of the free set avail.
    function automatic pick_t pick_pipe(logic [CLS_W-1:0] c, logic [NPIPE-1:0] avail);
        pick_t r;
        pipe_e h;
        r = '0;
        h = op_home(c);
        if (c == OP_INT) begin
            if (avail[PIPE_CX]) begin
                r.ok = 1'b1; r.pipe = PIPE_CX; r.mask = 4'b0001;
            end else if (avail[PIPE_SX]) begin
                r.ok = 1'b1; r.pipe = PIPE_SX; r.mask = 4'b0010;
            end
        end else if (c == OP_FCMP) begin
            if (avail[PIPE_FP] && avail[PIPE_CX]) begin
                r.ok = 1'b1; r.pipe = PIPE_FP; r.mask = 4'b1001;
            end
        end else if (avail[h]) begin
            r.ok   = 1'b1;
            r.pipe = h;
            r.mask = NPIPE'(1) << h;
        end
        return r;
    endfunction
endpackage

// File: rtl/sched_pipe_busy.sv
module sched_pipe_busy
    import sched_pkg::*;
#(
    parameter int NP = NPIPE,
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    claim,
    input  logic [NP*CW-1:0] hold,
    output logic [NP-1:0]    free
);
    typedef struct packed {
        logic [NP-1:0][CW-1:0] cnt;
    } busy_t;

    busy_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NP; p++) begin
            if (claim[p])
                st_d.cnt[p] = hold[p*CW +: CW];
            else if (st_q.cnt[p] != '0)
                st_d.cnt[p] = st_q.cnt[p] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar p = 0; p < NP; p++) begin : g_free
        assign free[p] = (st_q.cnt[p] == '0);

        // R6: a reserved pipe is never claimed again
        p_no_double_claim_r6: assert property (@(posedge clk) disable iff (rst)
            claim[p] |-> free[p]);
        // R6: a busy pipe counts down by one when not claimed
        p_busy_countdown_r6: assert property (@(posedge clk) disable iff (rst)
            (!free[p] && !claim[p]) |=> (st_q.cnt[p] == $past(st_q.cnt[p]) - 1'b1));
    end
endmodule

// File: rtl/sched_scoreboard.sv
module sched_scoreboard
    import sched_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int CW    = CNT_W,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         wr_en,
    input  logic [2*IDX_W-1:0] wr_idx,
    input  logic [2*CW-1:0]    wr_val,
    output logic [NREG-1:0]    pend
);
    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt;
    } sb_t;

    sb_t             st_d, st_q;
    logic [NREG-1:0] hit;

    always_comb begin
        st_d = st_q;
        hit  = '0;
        for (int r = 0; r < NREG; r++) begin
            if (st_q.cnt[r] != '0)
                st_d.cnt[r] = st_q.cnt[r] - 1'b1;
            // slot 1 is younger, so its write lands last
            for (int s = 0; s < 2; s++) begin
                if (wr_en[s] && wr_idx[s*IDX_W +: IDX_W] == IDX_W'(r)) begin
                    st_d.cnt[r] = wr_val[s*CW +: CW];
                    hit[r]      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar r = 0; r < NREG; r++) begin : g_pend
        assign pend[r] = (st_q.cnt[r] != '0);

        // R5: a ready register stays ready until something writes it
        p_ready_stays_r5: assert property (@(posedge clk) disable iff (rst)
            (!pend[r] && !hit[r]) |=> !pend[r]);
    end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         slot_valid,
    input  logic [2*CLS_W-1:0] slot_class,
    input  logic [2*IDX_W-1:0] slot_dst,
    input  logic [1:0]         slot_dst_en,
    input  logic [2*IDX_W-1:0] slot_srca,
    input  logic [1:0]         slot_srca_en,
    input  logic [2*IDX_W-1:0] slot_srcb,
    input  logic [1:0]         slot_srcb_en,
    output logic [1:0]         grant,
    output logic [2*PIPE_W-1:0] slot_pipe
);
    logic [NPIPE-1:0]       pipe_free;
    logic [NPIPE-1:0]       claim;
    logic [NPIPE*CNT_W-1:0] hold;
    logic [NREG-1:0]        pend;
    logic [1:0]             wr_en;
    logic [2*CNT_W-1:0]     wr_val;
    pick_t                  pk0, pk1;
    logic [1:0]             src_ok;
    logic                   raw_pair;

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            src_ok[s] = !(slot_srca_en[s] && pend[slot_srca[s*IDX_W +: IDX_W]])
                     && !(slot_srcb_en[s] && pend[slot_srcb[s*IDX_W +: IDX_W]]);
        end
        raw_pair = slot_dst_en[0] &&
                   ((slot_srca_en[1] && slot_srca[IDX_W +: IDX_W] == slot_dst[0 +: IDX_W]) ||
                    (slot_srcb_en[1] && slot_srcb[IDX_W +: IDX_W] == slot_dst[0 +: IDX_W]));

        pk0 = pick_pipe(slot_class[0 +: CLS_W], pipe_free);
        grant[0] = !rst && slot_valid[0] && src_ok[0] && pk0.ok;

        pk1 = pick_pipe(slot_class[CLS_W +: CLS_W],
                        pipe_free & ~(grant[0] ? pk0.mask : '0));
        grant[1] = grant[0] && slot_valid[1] && src_ok[1] && !raw_pair && pk1.ok;

        slot_pipe = {pk1.pipe, pk0.pipe};

        claim = '0;
        hold  = '0;
        for (int p = 0; p < NPIPE; p++) begin
            if (grant[0] && pk0.mask[p]) begin
                claim[p] = 1'b1;
                hold[p*CNT_W +: CNT_W] = op_occupancy(slot_class[0 +: CLS_W]) - 1'b1;
            end
            if (grant[1] && pk1.mask[p]) begin
                claim[p] = 1'b1;
                hold[p*CNT_W +: CNT_W] = op_occupancy(slot_class[CLS_W +: CLS_W]) - 1'b1;
            end
        end

        for (int s = 0; s < 2; s++) begin
            wr_en[s] = grant[s] && slot_dst_en[s];
            wr_val[s*CNT_W +: CNT_W] = op_latency(slot_class[s*CLS_W +: CLS_W]) - 1'b1;
        end
    end

    sched_pipe_busy #(.NP(NPIPE), .CW(CNT_W)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .claim (claim),
        .hold  (hold),
        .free  (pipe_free)
    );

    sched_scoreboard #(.NREG(NREG), .CW(CNT_W), .IDX_W(IDX_W)) u_sb (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (slot_dst),
        .wr_val (wr_val),
        .pend   (pend)
    );

    // R1: younger slot never issues ahead of the older one
    p_in_order_r1: assert property (@(posedge clk) disable iff (rst)
        grant[1] |-> grant[0]);
    // R1: grants only for valid slots
    p_grant_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (grant & ~slot_valid) == 2'b00);
    // R8: two issued slots are bound to distinct pipes
    p_distinct_pipe_r8: assert property (@(posedge clk) disable iff (rst)
        (&grant) |-> (slot_pipe[1:0] != slot_pipe[3:2]));
    // R7: an issued FP compare shuts the complex pipe to slot 1
    p_fcmp_blocks_cx_r7: assert property (@(posedge clk) disable iff (rst)
        (&grant && slot_class[0 +: CLS_W] == OP_FCMP) |-> (slot_pipe[3:2] != PIPE_CX));
endmodule

// File: tb/test_issue_sched.sv
module test_issue_sched;
    localparam int IW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  slot_valid;
    logic [9:0]  slot_class;
    logic [9:0]  slot_dst;
    logic [1:0]  slot_dst_en;
    logic [9:0]  slot_srca;
    logic [1:0]  slot_srca_en;
    logic [9:0]  slot_srcb;
    logic [1:0]  slot_srcb_en;
    logic [1:0]  grant;
    logic [3:0]  slot_pipe;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    issue_sched i_issue_sched (
        .clk          (clk),
        .rst          (rst),
        .slot_valid   (slot_valid),
        .slot_class   (slot_class),
        .slot_dst     (slot_dst),
        .slot_dst_en  (slot_dst_en),
        .slot_srca    (slot_srca),
        .slot_srca_en (slot_srca_en),
        .slot_srcb    (slot_srcb),
        .slot_srcb_en (slot_srcb_en),
        .grant        (grant),
        .slot_pipe    (slot_pipe)
    );

    function automatic int exp_lat(int c);
        case (c)
            0, 4, 11:         return 1;
            2, 5, 8:          return 2;
            1, 6, 9, 12, 16:  return 3;
            7, 10:            return 4;
            13:               return 5;
            3:                return 34;
            14:               return 19;
            15:               return 33;
            default:          return 1;
        endcase
    endfunction

    function automatic int exp_occ(int c);
        if (c == 3)  return 33;
        if (c == 14) return 15;
        if (c == 15) return 29;
        return 1;
    endfunction

    function automatic int exp_pipe(int c);
        if (c >= 9 && c <= 12) return 2;
        if (c >= 13)           return 3;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        slot_valid = '0; slot_class = '0; slot_dst = '0; slot_dst_en = '0;
        slot_srca = '0; slot_srca_en = '0; slot_srcb = '0; slot_srcb_en = '0;
    endtask

    task automatic set_slot(int s, int c, int d, int de, int sa, int sae, int sb, int sbe);
        slot_valid[s]          = 1'b1;
        slot_class[s*5 +: 5]   = 5'(c);
        slot_dst[s*IW +: IW]   = IW'(d);
        slot_dst_en[s]         = 1'(de);
        slot_srca[s*IW +: IW]  = IW'(sa);
        slot_srca_en[s]        = 1'(sae);
        slot_srcb[s*IW +: IW]  = IW'(sb);
        slot_srcb_en[s]        = 1'(sbe);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // present slot 0 each cycle until granted; return cycles waited
    task automatic wait_grant(output int k);
        k = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            #1;
            if (grant[0]) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic pair(string req, int c0, int c1, int eg, int ep0, int ep1);
        do_reset();
        idle();
        set_slot(0, c0, 0, 0, 0, 0, 0, 0);
        set_slot(1, c1, 0, 0, 0, 0, 0, 0);
        #1;
        chk(req, grant, eg);
        if (eg[0]) chk(req, slot_pipe[1:0], ep0);
        if (eg[1]) chk(req, slot_pipe[3:2], ep1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int k;
        idle();
        // R10: no grant while reset is high
        @(negedge clk);
        set_slot(0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R10 reset grant", grant, 0);

        // sweep every class: pipe binding, result latency, occupancy
        for (int c = 0; c <= 16; c++) begin
            do_reset();
            idle();
            set_slot(0, c, 1, 1, 0, 0, 0, 0);
            #1;
            chk("R2 R3 R4 R7 issue", grant[0], 1);
            chk("R2 R3 R4 R7 pipe", slot_pipe[1:0], exp_pipe(c));
            @(negedge clk);
            idle();
            set_slot(0, 9, 0, 0, 1, 1, 0, 0);
            #1;
            k = grant[0] ? 1 : 0;
            if (k == 0) begin
                for (int i = 2; i <= 40; i++) begin
                    @(negedge clk);
                    #1;
                    if (grant[0]) begin k = i; break; end
                end
            end
            chk("R5 latency", k, exp_lat(c));

            do_reset();
            idle();
            set_slot(0, c, 0, 0, 0, 0, 0, 0);
            #1;
            wait_grant(k);
            chk("R6 occupancy", k, exp_occ(c));
        end

        // pairs: steering and priority
        pair("R2 int pair",        0, 0, 3, 0, 1);
        pair("R2 mul then int",    1, 0, 3, 0, 1);
        pair("R8 int then mul",    0, 1, 1, 0, 0);
        pair("R8 load then store", 9, 11, 1, 2, 0);
        pair("R4 load and int",    9, 0, 3, 2, 0);
        pair("R7 fcmp then int",   16, 0, 3, 3, 1);
        pair("R7 fcmp then branch",16, 4, 1, 3, 0);
        pair("R4 fp and fp load",  13, 10, 3, 3, 2);

        // R1: slot 1 alone never issues
        do_reset();
        idle();
        set_slot(1, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R1 lone younger", grant, 0);

        // R1: stalled older holds younger that could go to simple pipe
        do_reset();
        idle();
        set_slot(0, 3, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        idle();
        set_slot(0, 1, 0, 0, 0, 0, 0, 0);
        set_slot(1, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R1 held pair", grant, 0);

        // R9 and R11: same-cycle dependency
        do_reset();
        idle();
        set_slot(0, 0, 5, 1, 0, 0, 0, 0);
        set_slot(1, 0, 6, 1, 5, 1, 0, 0);
        #1;
        chk("R9 pair raw", grant, 1);
        do_reset();
        idle();
        set_slot(0, 0, 5, 1, 0, 0, 0, 0);
        set_slot(1, 0, 6, 1, 7, 1, 5, 1);
        #1;
        chk("R9 pair raw srcb", grant, 1);
        do_reset();
        idle();
        set_slot(0, 0, 5, 1, 0, 0, 0, 0);
        set_slot(1, 0, 6, 1, 5, 0, 5, 0);
        #1;
        chk("R11 pair disabled src", grant, 3);

        // R11: disabled source ignores a pending register
        do_reset();
        idle();
        set_slot(0, 3, 4, 1, 0, 0, 0, 0);
        @(negedge clk);
        idle();
        set_slot(0, 9, 0, 0, 4, 0, 4, 0);
        #1;
        chk("R11 disabled src", grant[0], 1);
        @(negedge clk);
        idle();
        set_slot(0, 9, 0, 0, 0, 0, 4, 1);
        #1;
        chk("R5 enabled srcb held", grant[0], 0);

        // R10: reset clears busy pipe and pending register
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        set_slot(0, 1, 0, 0, 4, 1, 0, 0);
        set_slot(1, 9, 0, 0, 4, 1, 0, 0);
        #1;
        chk("R10 cleared state", grant, 3);

        @(negedge clk);
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule